// File: doc/BRIEF.md
# Pulse-Density Bit-Stream Generator

This block turns a sequence of 16-bit unsigned samples into a one-bit pulse-density stream. An external low-pass filter averages that stream into an analog voltage. Three modes are available. The first shifts each sample word straight out, one bit per clock. The second runs a first-order delta-sigma modulator. The third runs the same modulator after a two-stage CIC interpolator, whose grown result is truncated back to 16 bits. In the delta-sigma modes the ones-density of the output follows the sample value.

Samples are pulled from a buffer with a one-cycle request. A word is taken when the buffer marks it valid; otherwise the previous word is reused. One period counter runs per sample period. It paces the requests, a one-clock converter trigger placed at a programmable offset, and a mute line for an external transmitter. Mute is held while the block is stopped and during the first sample period after start. The mode may only be written while stopped. The intended order is stop strobe, mode write, start strobe.

A chip places two copies on the same clock to get two synchronous streams.

Top module: `pdm_bitgen`

## Requirements
- R1: After reset and after a stop strobe, pdm_out is 0, mute is 1, trig is 0 and smp_req is 0. Reset leaves mode at 0 and mode_err at 0.
- R2: The first clock after a start strobe is taken is a fetch cycle (smp_req high). A start strobe while running has no effect. A start and stop strobe in the same cycle leaves the block stopped.
- R3: In mode 0 (shift) the sample period is 16 clocks. The word captured in a fetch cycle appears on pdm_out MSB first, in the 16 clocks that follow.
- R4: In mode 2 (direct delta-sigma; mode 3 behaves the same) the sample period is osr+1 clocks. With a constant sample X, the number of ones in any window of W clocks in steady state is floor(W*X/65536) or one more.
- R5: In mode 1 (CIC) the sample period is 16 clocks whatever osr holds. With a constant sample X, the steady ones-density obeys the same bound as R4.
- R6: In mode 1 a step from 0 to 0xFFFF is spread over the period: the 16 clocks after the first fetch hold between 4 and 12 ones.
- R7: trig is high for exactly the clocks in which the period counter equals trig_ofs. An offset of 0 coincides with smp_req, and an offset at or beyond the period length never fires.
- R8: A mode_wr while stopped loads mode_in into mode. A mode_wr while running leaves mode unchanged and sets mode_err, which stays set until reset.
- R9: mute falls in the second fetch cycle after start, one full sample period later.
- R10: When smp_valid is low in a fetch cycle, the previously captured sample is used again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_start | input | 1 | Start strobe |
| run_stop | input | 1 | Stop strobe, wins over start |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode value: 0 shift, 1 CIC delta-sigma, 2 or 3 direct delta-sigma |
| osr | input | PW | Direct mode period minus one |
| trig_ofs | input | PW | Trigger position within the period |
| smp_valid | input | 1 | Buffer has a word on smp_data |
| smp_data | input | DW | Sample word |
| smp_req | output | 1 | Fetch cycle; the word is taken at this clock edge |
| pdm_out | output | 1 | Bit-stream output |
| trig | output | 1 | Converter trigger pulse |
| mute | output | 1 | Transmitter mute |
| mode_err | output | 1 | Sticky flag for a mode write while running |
| mode | output | 2 | Current mode |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the trigger and the sample fetch. It is provoked with a zero offset in direct mode, and the bench requires trig to equal smp_req in every clock of the run. The bench also moves the offset past the period and requires no pulse at all. The second pair is start and stop strobes in one cycle. The bench requires that no request follows. A start strobe during a running shift word must leave the shifted bits intact.

// File: rtl/pdm_bitgen.sv
module pdm_bitgen #(
  parameter int DW   = 16,
  parameter int PW   = 8,
  parameter int RLOG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          run_stop,
  input  logic          mode_wr,
  input  logic [1:0]    mode_in,
  input  logic [PW-1:0] osr,
  input  logic [PW-1:0] trig_ofs,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          smp_req,
  output logic          pdm_out,
  output logic          trig,
  output logic          mute,
  output logic          mode_err,
  output logic [1:0]    mode
);
  localparam int IW = DW + RLOG;
  localparam logic [PW-1:0] SH_LAST  = PW'(DW - 1);
  localparam logic [PW-1:0] CIC_LAST = PW'((1 << RLOG) - 1);

  logic          running, warm, cy;
  logic [PW-1:0] pcnt, last;
  logic [DW-1:0] xd, sh, acc, nxt, dsin;
  logic [IW-1:0] c1, c1d, c2, i1, i2;
  logic [DW:0]   sum;

  assign last    = (mode == 2'd0) ? SH_LAST : (mode == 2'd1) ? CIC_LAST : osr;
  assign smp_req = running && (pcnt == '0);
  assign nxt     = smp_valid ? smp_data : xd;
  assign c1      = IW'(nxt) - IW'(xd);
  assign c2      = c1 - c1d;
  assign dsin    = (mode == 2'd1) ? DW'(i2 >> RLOG) : xd;
  assign sum     = {1'b0, acc} + {1'b0, dsin};
  assign pdm_out = running && ((mode == 2'd0) ? sh[DW-1] : cy);
  assign trig    = running && (pcnt == trig_ofs);
  assign mute    = !(running && warm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      warm     <= 1'b0;
      cy       <= 1'b0;
      pcnt     <= '0;
      xd       <= '0;
      sh       <= '0;
      acc      <= '0;
      c1d      <= '0;
      i1       <= '0;
      i2       <= '0;
      mode     <= 2'd0;
      mode_err <= 1'b0;
    end else begin
      if (mode_wr) begin
        if (running) mode_err <= 1'b1;
        else         mode     <= mode_in;
      end
      if (run_stop || !running) begin
        running <= run_start && !run_stop;
        warm    <= 1'b0;
        cy      <= 1'b0;
        pcnt    <= '0;
        xd      <= '0;
        sh      <= '0;
        acc     <= '0;
        c1d     <= '0;
        i1      <= '0;
        i2      <= '0;
      end else begin
        pcnt <= (pcnt == last) ? '0 : pcnt + 1'b1;
        if (pcnt == last) warm <= 1'b1;
        if (smp_req) begin
          xd  <= nxt;
          sh  <= nxt;
          c1d <= c1;
          i1  <= i1 + c2;
        end else begin
          sh <= sh << 1;
        end
        i2        <= i2 + i1;
        {cy, acc} <= sum;
      end
    end
  end
endmodule

// File: rtl/pdm_bitgen_chk.sv
module pdm_bitgen_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          run_stop,
  input logic          mode_wr,
  input logic          smp_req,
  input logic          pdm_out,
  input logic          trig,
  input logic          mute,
  input logic          mode_err,
  input logic [1:0]    mode,
  input logic [PW-1:0] trig_ofs
);
  a_r1_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |=> (!pdm_out && mute && !smp_req && !trig));

  a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode_wr) |=> ((mode == $past(mode)) && mode_err));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  a_r7_trig_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (trig_ofs == '0)) |-> (trig == smp_req));

  a_r9_mute_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> smp_req);

  a_r3_shift_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && (mode == 2'd0)) |=> !smp_req);
endmodule

bind pdm_bitgen pdm_bitgen_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .running  (running),
  .run_stop (run_stop),
  .mode_wr  (mode_wr),
  .smp_req  (smp_req),
  .pdm_out  (pdm_out),
  .trig     (trig),
  .mute     (mute),
  .mode_err (mode_err),
  .mode     (mode),
  .trig_ofs (trig_ofs)
);

// File: tb/sim_pdm_bitgen.sv
module sim_pdm_bitgen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, run_start, run_stop, mode_wr, smp_valid;
  logic [1:0]  mode_in;
  logic [7:0]  osr, trig_ofs;
  logic [15:0] smp_data;
  logic        smp_req, pdm_out, trig, mute, mode_err;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pdm_bitgen u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_stop(run_stop),
    .mode_wr(mode_wr), .mode_in(mode_in), .osr(osr), .trig_ofs(trig_ofs),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_req(smp_req),
    .pdm_out(pdm_out), .trig(trig), .mute(mute), .mode_err(mode_err), .mode(mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dens_lo(input int w, input int x);
    longint p;
    p = longint'(w) * longint'(x);
    return int'(p >> 16);
  endfunction

  task automatic start_run();
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  task automatic stop_run();
    run_stop = 1'b1;
    @(negedge clk);
    run_stop = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_in = m;
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic count_ones(input int w, output int n);
    n = 0;
    repeat (w) begin
      @(negedge clk);
      n += int'(pdm_out);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, lo, x;
    logic [15:0] w, got;
    bit trig_ok;
    rst_n = 1'b0; run_start = 1'b0; run_stop = 1'b0; mode_wr = 1'b0;
    mode_in = 2'd0; osr = 8'd0; trig_ofs = 8'd5; smp_valid = 1'b1; smp_data = '0;
    x = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(pdm_out == 1'b0, "R1 pdm_out", pdm_out, 0);
    chk(mute == 1'b1, "R1 mute", mute, 1);
    chk(smp_req == 1'b0 && trig == 1'b0, "R1 req/trig", {smp_req, trig}, 0);
    chk(mode == 2'd0 && mode_err == 1'b0, "R1 mode/err", {mode_err, mode}, 0);

    // R3 shift mode with random words, R7 trigger at offset 5, R9 mute
    start_run();
    chk(smp_req == 1'b1, "R2 first fetch", smp_req, 1);
    for (int wi = 0; wi < 6; wi++) begin
      w = 16'($urandom());
      smp_data = w;
      trig_ok = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        @(negedge clk);
        got[b] = pdm_out;
        if (trig != (((16 - b) % 16) == 5)) trig_ok = 1'b0;
        if (wi == 0 && b == 1) chk(mute == 1'b1, "R9 mute held", mute, 1);
        if (wi == 0 && b == 0) chk(mute == 1'b0, "R9 mute release", mute, 0);
        if (wi == 2 && b == 8) run_start = 1'b1;
        if (wi == 2 && b == 7) run_start = 1'b0;
      end
      chk(got == w, (wi == 2) ? "R2 R3 start ignored" : "R3 shift word", got, w);
      chk(trig_ok, "R7 trigger offset 5", trig_ok, 1);
      chk(smp_req == 1'b1, "R3 period 16", smp_req, 1);
    end

    // R8 write while running
    mode_in = 2'd2;
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    chk(mode == 2'd0, "R8 mode locked", mode, 0);
    chk(mode_err == 1'b1, "R8 error flag", mode_err, 1);

    stop_run();
    chk(pdm_out == 1'b0 && smp_req == 1'b0 && trig == 1'b0, "R1 after stop",
        {pdm_out, smp_req, trig}, 0);
    chk(mute == 1'b1, "R1 mute after stop", mute, 1);
    n = 0;
    repeat (5) begin
      @(negedge clk);
      n += int'(pdm_out) + int'(smp_req);
    end
    chk(n == 0, "R1 stays quiet", n, 0);

    // R2 start and stop together
    run_start = 1'b1;
    run_stop = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    run_stop = 1'b0;
    chk(smp_req == 1'b0, "R2 stop wins", smp_req, 0);
    @(negedge clk);
    chk(smp_req == 1'b0, "R2 still stopped", smp_req, 0);

    // R4 direct delta-sigma, R7 zero offset, R10 invalid fetch
    set_mode(2'd2);
    chk(mode == 2'd2, "R8 write while stopped", mode, 2);
    chk(mode_err == 1'b1, "R8 error sticky", mode_err, 1);
    osr = 8'd39;
    trig_ofs = 8'd0;
    for (int t = 0; t < 5; t++) begin
      int last_req, cyc;
      bit gap_ok, tz_ok;
      x = (t == 0) ? 0 : (t == 1) ? 65535 : int'($urandom() & 32'hFFFF);
      smp_data = 16'(x);
      start_run();
      repeat (3) @(negedge clk);
      n = 0; last_req = 0; cyc = 3; gap_ok = 1'b1; tz_ok = 1'b1;
      repeat (200) begin
        @(negedge clk);
        cyc++;
        n += int'(pdm_out);
        if (trig != smp_req) tz_ok = 1'b0;
        if (smp_req) begin
          if (cyc - last_req != 40) gap_ok = 1'b0;
          last_req = cyc;
        end
      end
      lo = dens_lo(200, x);
      chk(n == lo || n == lo + 1, "R4 density", n, lo);
      chk(gap_ok, "R4 period osr+1", gap_ok, 1);
      chk(tz_ok, "R7 trigger with fetch", tz_ok, 1);
      if (t == 4) begin
        smp_valid = 1'b0;
        smp_data = ~16'(x);
        repeat (45) @(negedge clk);
        count_ones(200, n);
        chk(n == lo || n == lo + 1, "R10 sample held", n, lo);
        smp_valid = 1'b1;
      end
      stop_run();
    end

    // R7 offset beyond period
    trig_ofs = 8'd50;
    smp_data = 16'h8000;
    start_run();
    n = int'(trig);
    repeat (120) begin
      @(negedge clk);
      n += int'(trig);
    end
    chk(n == 0, "R7 offset past period", n, 0);
    stop_run();

    // R5/R6 CIC mode
    set_mode(2'd1);
    osr = 8'd3;
    trig_ofs = 8'd0;
    smp_data = 16'hFFFF;
    start_run();
    count_ones(16, n);
    chk(n >= 4 && n <= 12, "R6 interpolated step", n, 8);
    chk(smp_req == 1'b1, "R5 period 16", smp_req, 1);
    repeat (30) @(negedge clk);
    count_ones(160, n);
    lo = dens_lo(160, 65535);
    chk(n == lo || n == lo + 1, "R5 full-scale density", n, lo);
    stop_run();
    for (int t = 0; t < 3; t++) begin
      x = int'($urandom() & 32'hFFFF);
      smp_data = 16'(x);
      start_run();
      repeat (40) @(negedge clk);
      count_ones(160, n);
      lo = dens_lo(160, x);
      chk(n == lo || n == lo + 1, "R5 steady density", n, lo);
      stop_run();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule